// File: doc/BRIEF.md
# Nonvolatile Memory Program-Erase Controller

This block is the control logic that sits in front of a small 128-byte on-chip nonvolatile array. It sits on a simple CPU bus with an address, write data, a read strobe and a write strobe. Through one control register, software picks an operation: program, byte erase, block erase or whole-array erase. The register also holds the bits that arm the bus latch, select the memory clock source and switch on programming power. The block enforces the order in which those bits may be set.

A typical program sequence has four steps. Software sets the latch bit and writes the target byte through the normal array address, which captures the address and data. It then sets the power-enable bit, and finally clears the latch bit. The operation is applied to the array on the clock edge where power-enable turns on. A block erase covers the aligned 32-byte group that contains the captured address. A whole-array erase clears every byte. While a captured write is pending, array reads return 0xFF. The array model here holds the bytes as registers, and the pump enable output marks when high voltage would be applied.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: While the reset is asserted and after it is released, the control register reads 0x00, pump_en and rc_sel are 0, and every array byte reads 0x00.
- R2: The control register is at address 0x0C0. Bit 0 is power enable, bit 2 is the latch, bit 3 is the clock select, and bits [5:4] are the operation mode. Bits 7, 6 and 1 always read 0. The register reads back correctly at any time, including while reads of the array are blocked.
- R3: The power-enable bit takes the written value only if the latch bit was already 1 before the write. pump_en equals the power-enable bit.
- R4: A write of 1 to both the latch bit and the power-enable bit, made while the latch bit is 0, sets the latch and leaves power enable at 0.
- R5: A write that clears the latch bit also clears power enable and discards any captured array write.
- R6: An array write (address 0x140 to 0x1BF) made while the latch bit is 1 captures that address and data. An array write made while the latch bit is 0 leaves the array unchanged.
- R7: An array read returns 0xFF while the latch bit is 1 and a write has been captured. Otherwise an array read returns the stored byte. A read of any address that maps to neither the register nor the array returns 0x00.
- R8: Mode 00 ORs the captured data into the captured byte only.
- R9: Mode 01 clears the captured byte to 0x00 and leaves every other byte unchanged.
- R10: Mode 10 clears the aligned 32-byte block that holds the captured address: 0x140, 0x160, 0x180 or 0x1A0 up to the next boundary. Other blocks are unchanged.
- R11: Mode 11 clears all 128 bytes.
- R12: The array changes only on the write that turns power enable from 0 to 1 while a write is captured. It uses the mode value written in that same write. A second write that keeps power enable at 1 does not repeat the operation. Turning power on with nothing captured changes nothing.
- R13: rc_sel follows the clock-select bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 9 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Read strobe; read data is combinational from address |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_rdata | output | 8 | Read data, 0x00 when no read is strobed |
| pump_en | output | 1 | High-voltage supply enable |
| rc_sel | output | 1 | Memory clock source: 1 selects the internal RC oscillator |

## Verification
A broken interlock shows on pump_en and in the register readback on the first clock edge after the offending register write. So a power bit set from an unlatched state, or a power bit left on after the latch drops, is visible one write later. A wrong captured address or a wrong byte select stays hidden until the latch is cleared. It then shows as the wrong byte values on the array reads that follow, so each operation is checked by reading inside and outside its span. An operation that fires at the wrong time changes the array on an edge where pump_en did not rise. That change is visible on the next unblocked read.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    OP_PROGRAM   = 2'b00,
    OP_ERASE_ONE = 2'b01,
    OP_ERASE_BLK = 2'b10,
    OP_ERASE_ALL = 2'b11
  } nvm_op_e;

  localparam int BIT_PWR   = 0;
  localparam int BIT_LATCH = 2;
  localparam int BIT_RCSEL = 3;
  localparam int BIT_MODE  = 4;
endpackage

// File: rtl/nvm_rst_sync.sv
module nvm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg
  import nvm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              wr_latch,
  input  logic              wr_pwr,
  input  logic              wr_rcsel,
  input  nvm_op_e           wr_mode,
  input  logic              arr_wr,
  input  logic [IDX_W-1:0]  arr_idx,
  input  logic [DATA_W-1:0] arr_data,
  output logic              latch_q,
  output logic              pwr_q,
  output logic              rcsel_q,
  output nvm_op_e           mode_q,
  output logic              cap_q,
  output logic [IDX_W-1:0]  cap_idx_q,
  output logic [DATA_W-1:0] cap_data_q,
  output logic              fire
);
  logic              latch_d, pwr_d, rcsel_d, cap_d;
  nvm_op_e           mode_d;
  logic [IDX_W-1:0]  cap_idx_d;
  logic [DATA_W-1:0] cap_data_d;
  logic              cap_en;

  // next state
  always_comb begin
    latch_d    = latch_q;
    pwr_d      = pwr_q;
    rcsel_d    = rcsel_q;
    mode_d     = mode_q;
    cap_d      = cap_q;
    cap_en     = 1'b0;
    cap_idx_d  = cap_idx_q;
    cap_data_d = cap_data_q;
    if (ctrl_wr) begin
      latch_d = wr_latch;
      rcsel_d = wr_rcsel;
      mode_d  = wr_mode;
      // power only follows the data when already latched and staying latched
      pwr_d   = latch_q & wr_latch & wr_pwr;
      if (!wr_latch) cap_d = 1'b0;
    end else if (arr_wr && latch_q) begin
      cap_d      = 1'b1;
      cap_en     = 1'b1;
      cap_idx_d  = arr_idx;
      cap_data_d = arr_data;
    end
  end

  assign fire = ctrl_wr & latch_q & wr_latch & wr_pwr & ~pwr_q & cap_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      pwr_q   <= 1'b0;
      rcsel_q <= 1'b0;
      mode_q  <= OP_PROGRAM;
      cap_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      pwr_q   <= pwr_d;
      rcsel_q <= rcsel_d;
      mode_q  <= mode_d;
      cap_q   <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_idx_q  <= '0;
      cap_data_q <= '0;
    end else if (cap_en) begin
      cap_idx_q  <= cap_idx_d;
      cap_data_q <= cap_data_d;
    end
  end
endmodule

// File: rtl/nvm_span_dec.sv
module nvm_span_dec
  import nvm_pkg::*;
#(
  parameter int ARR_BYTES = 128,
  parameter int BLK_BYTES = 32
) (
  input  nvm_op_e                          mode,
  input  logic [$clog2(ARR_BYTES)-1:0]     idx,
  output logic [ARR_BYTES-1:0]             sel
);
  localparam int IDX_W  = $clog2(ARR_BYTES);
  localparam int BLK_SH = $clog2(BLK_BYTES);

  for (genvar i = 0; i < ARR_BYTES; i++) begin : g_sel
    localparam logic [IDX_W-1:0] IDX_I = IDX_W'(i);
    always_comb begin
      unique case (mode)
        OP_PROGRAM,
        OP_ERASE_ONE: sel[i] = (idx == IDX_I);
        OP_ERASE_BLK: sel[i] = (idx[IDX_W-1:BLK_SH] == IDX_I[IDX_W-1:BLK_SH]);
        default:      sel[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int ARR_BYTES = 128,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fire,
  input  logic                         erase,
  input  logic [ARR_BYTES-1:0]         sel,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [$clog2(ARR_BYTES)-1:0] rd_idx,
  output logic [DATA_W-1:0]            rd_data,
  output logic [ARR_BYTES*DATA_W-1:0]  flat
);
  logic [DATA_W-1:0] mem_q [ARR_BYTES];

  for (genvar i = 0; i < ARR_BYTES; i++) begin : g_cell
    logic [DATA_W-1:0] cell_d;
    logic              cell_en;

    always_comb begin
      cell_en = fire & sel[i];
      cell_d  = erase ? '0 : (mem_q[i] | wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (cell_en) mem_q[i] <= cell_d;
    end

    assign flat[i*DATA_W +: DATA_W] = mem_q[i];
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
  import nvm_pkg::*;
#(
  parameter int                ADDR_W    = 9,
  parameter int                DATA_W    = 8,
  parameter int                ARR_BYTES = 128,
  parameter int                BLK_BYTES = 32,
  parameter logic [ADDR_W-1:0] ARR_BASE  = 9'h140,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 9'h0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pump_en,
  output logic              rc_sel
);
  localparam int                IDX_W    = $clog2(ARR_BYTES);
  localparam logic [ADDR_W-1:0] ARR_LAST = ARR_BASE + ADDR_W'(ARR_BYTES - 1);

  logic              rst_ns;
  logic              ctrl_hit, in_arr, ctrl_wr, arr_wr;
  logic [IDX_W-1:0]  bus_idx;
  logic              latch_q, pwr_q, rcsel_q, cap_q, fire;
  nvm_op_e           mode_q;
  logic [IDX_W-1:0]  cap_idx_q;
  logic [DATA_W-1:0] cap_data_q;
  logic [ARR_BYTES-1:0]        sel;
  logic [DATA_W-1:0]           arr_rd;
  logic [ARR_BYTES*DATA_W-1:0] arr_flat;
  logic [DATA_W-1:0]           ctrl_val;
  logic                        read_block;

  nvm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  assign ctrl_hit = (bus_addr == CTRL_ADDR);
  assign in_arr   = (bus_addr >= ARR_BASE) && (bus_addr <= ARR_LAST);
  assign bus_idx  = bus_addr[IDX_W-1:0] - ARR_BASE[IDX_W-1:0];
  assign ctrl_wr  = bus_wr & ctrl_hit;
  assign arr_wr   = bus_wr & in_arr;

  nvm_ctrl_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_ns),
    .ctrl_wr   (ctrl_wr),
    .wr_latch  (bus_wdata[BIT_LATCH]),
    .wr_pwr    (bus_wdata[BIT_PWR]),
    .wr_rcsel  (bus_wdata[BIT_RCSEL]),
    .wr_mode   (nvm_op_e'(bus_wdata[BIT_MODE +: 2])),
    .arr_wr    (arr_wr),
    .arr_idx   (bus_idx),
    .arr_data  (bus_wdata),
    .latch_q   (latch_q),
    .pwr_q     (pwr_q),
    .rcsel_q   (rcsel_q),
    .mode_q    (mode_q),
    .cap_q     (cap_q),
    .cap_idx_q (cap_idx_q),
    .cap_data_q(cap_data_q),
    .fire      (fire)
  );

  // operation uses the mode carried by the power-on write itself
  nvm_op_e fire_mode;
  assign fire_mode = nvm_op_e'(bus_wdata[BIT_MODE +: 2]);

  nvm_span_dec #(.ARR_BYTES(ARR_BYTES), .BLK_BYTES(BLK_BYTES)) u_span (
    .mode(fire_mode),
    .idx (cap_idx_q),
    .sel (sel)
  );

  nvm_cell_array #(.ARR_BYTES(ARR_BYTES), .DATA_W(DATA_W)) u_arr (
    .clk    (clk),
    .rst_n  (rst_ns),
    .fire   (fire),
    .erase  (fire_mode != OP_PROGRAM),
    .sel    (sel),
    .wdata  (cap_data_q),
    .rd_idx (bus_idx),
    .rd_data(arr_rd),
    .flat   (arr_flat)
  );

  always_comb begin
    ctrl_val                  = '0;
    ctrl_val[BIT_PWR]         = pwr_q;
    ctrl_val[BIT_LATCH]       = latch_q;
    ctrl_val[BIT_RCSEL]       = rcsel_q;
    ctrl_val[BIT_MODE +: 2]   = mode_q;
  end

  assign read_block = latch_q & cap_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (ctrl_hit)    bus_rdata = ctrl_val;
      else if (in_arr) bus_rdata = read_block ? '1 : arr_rd;
    end
  end

  assign pump_en = pwr_q;
  assign rc_sel  = rcsel_q;
endmodule

// File: rtl/nvm_pe_ctrl_chk.sv
module nvm_pe_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int FLAT_W = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pump_en,
  input logic              latch_q,
  input logic              cap_q,
  input logic              ctrl_wr,
  input logic              ctrl_hit,
  input logic              in_arr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [FLAT_W-1:0] arr_flat
);
  a_r3_pump_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    pump_en |-> latch_q);

  a_r4_no_power_from_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !latch_q) |=> !pump_en);

  a_r5_latch_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_q) |-> (!pump_en && !cap_q));

  a_r7_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_arr && latch_q && cap_q) |-> (bus_rdata == '1));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ctrl_hit) |-> (bus_rdata[7:6] == 2'b00 && !bus_rdata[1]));

  a_r12_array_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pump_en) |-> $stable(arr_flat));
endmodule

bind nvm_pe_ctrl nvm_pe_ctrl_chk #(.DATA_W(DATA_W), .FLAT_W(ARR_BYTES*DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ns),
  .pump_en  (pump_en),
  .latch_q  (latch_q),
  .cap_q    (cap_q),
  .ctrl_wr  (ctrl_wr),
  .ctrl_hit (ctrl_hit),
  .in_arr   (in_arr),
  .bus_rd   (bus_rd),
  .bus_rdata(bus_rdata),
  .arr_flat (arr_flat)
);

// File: tb/nvm_pe_ctrl_bench.sv
`timescale 1ns/1ps
module nvm_pe_ctrl_bench;
  localparam logic [8:0] CTRL = 9'h0C0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       pump_en, rc_sel;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  nvm_pe_ctrl u_nvm_pe_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .pump_en(pump_en), .rc_sel(rc_sel)
  );

  // {wdata, expected readback, expected pump_en, expected rc_sel}
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {8'h05, 8'h04, 1'b0, 1'b0},
    {8'h05, 8'h05, 1'b1, 1'b0},
    {8'h3D, 8'h3D, 1'b1, 1'b1},
    {8'hC9, 8'h08, 1'b0, 1'b1},
    {8'h01, 8'h00, 1'b0, 1'b0},
    {8'h14, 8'h14, 1'b0, 1'b0},
    {8'h15, 8'h15, 1'b1, 1'b0},
    {8'h11, 8'h10, 1'b0, 1'b0},
    {8'hFF, 8'h3C, 1'b0, 1'b1},
    {8'hFF, 8'h3D, 1'b1, 1'b1},
    {8'h00, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic op(input logic [1:0] mode, input logic [8:0] a, input logic [7:0] d);
    wr(CTRL, {2'b00, mode, 4'b0100});
    wr(a, d);
    wr(CTRL, {2'b00, mode, 4'b0101});
    wr(CTRL, 8'h00);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    // R1 during and after reset
    repeat (3) @(negedge clk);
    rd(CTRL, v); check("R1 ctrl in reset", v, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(CTRL, v); check("R1 ctrl after reset", v, 8'h00);
    check("R1 pump_en", {7'd0, pump_en}, 8'h00);
    check("R1 rc_sel", {7'd0, rc_sel}, 8'h00);
    rd(9'h140, v); check("R1 array low", v, 8'h00);
    rd(9'h1BF, v); check("R1 array high", v, 8'h00);

    // R2 R3 R4 R5 R13 register table
    for (int i = 0; i < NV; i++) begin
      wr(CTRL, VEC[i][17:10]);
      rd(CTRL, v);
      check($sformatf("R2/R3/R4 vec%0d readback", i), v, VEC[i][9:2]);
      check($sformatf("R3/R5 vec%0d pump_en", i), {7'd0, pump_en}, {7'd0, VEC[i][1]});
      check($sformatf("R13 vec%0d rc_sel", i), {7'd0, rc_sel}, {7'd0, VEC[i][0]});
    end

    // R7 unmapped address
    rd(9'h000, v); check("R7 unmapped read", v, 8'h00);

    // R6 unlatched write ignored
    wr(9'h150, 8'hA5);
    rd(9'h150, v); check("R6 unlatched write ignored", v, 8'h00);

    // R6 R7 R8 program with blocked read
    wr(CTRL, 8'h04);
    rd(9'h150, v); check("R7 latched no capture reads normal", v, 8'h00);
    wr(9'h150, 8'hA5);
    rd(9'h150, v); check("R7 blocked read", v, 8'hFF);
    rd(9'h170, v); check("R7 blocked other byte", v, 8'hFF);
    rd(CTRL, v);   check("R2 ctrl readable while blocked", v, 8'h04);
    wr(CTRL, 8'h05);
    check("R3 pump on", {7'd0, pump_en}, 8'h01);
    rd(9'h150, v); check("R7 still blocked after fire", v, 8'hFF);
    wr(CTRL, 8'h00);
    rd(9'h150, v); check("R8 programmed byte", v, 8'hA5);
    rd(9'h151, v); check("R8 neighbour untouched", v, 8'h00);
    op(2'b00, 9'h150, 8'h0F);
    rd(9'h150, v); check("R8 OR into byte", v, 8'hAF);

    op(2'b00, 9'h140, 8'h11);
    op(2'b00, 9'h15F, 8'h22);
    op(2'b00, 9'h160, 8'h33);
    op(2'b00, 9'h1BF, 8'h44);

    // R9 byte erase
    op(2'b01, 9'h150, 8'h77);
    rd(9'h150, v); check("R9 byte erased", v, 8'h00);
    rd(9'h140, v); check("R9 other byte kept", v, 8'h11);
    rd(9'h15F, v); check("R9 other byte kept 2", v, 8'h22);

    // R10 block erase
    op(2'b10, 9'h145, 8'h00);
    rd(9'h140, v); check("R10 block start erased", v, 8'h00);
    rd(9'h15F, v); check("R10 block end erased", v, 8'h00);
    rd(9'h160, v); check("R10 next block kept", v, 8'h33);
    rd(9'h1BF, v); check("R10 last block kept", v, 8'h44);

    // R12 no refire while power held
    wr(CTRL, 8'h04);
    wr(9'h160, 8'h0C);
    wr(CTRL, 8'h05);
    wr(9'h1BF, 8'h80);
    wr(CTRL, 8'h05);
    wr(CTRL, 8'h00);
    rd(9'h160, v); check("R12 first fire applied", v, 8'h3F);
    rd(9'h1BF, v); check("R12 held power no refire", v, 8'h44);

    // R12 power rise with nothing captured
    wr(CTRL, 8'h04);
    wr(CTRL, 8'h35);
    wr(CTRL, 8'h00);
    rd(9'h160, v); check("R12 no capture no change", v, 8'h3F);

    // R5 latch drop discards capture
    wr(CTRL, 8'h04);
    wr(9'h160, 8'h40);
    wr(CTRL, 8'h00);
    rd(9'h160, v); check("R5 read unblocked after drop", v, 8'h3F);
    wr(CTRL, 8'h04);
    wr(CTRL, 8'h05);
    wr(CTRL, 8'h00);
    rd(9'h160, v); check("R5 discarded capture not applied", v, 8'h3F);

    // R12 mode taken from power-on write; R11 bulk erase
    wr(CTRL, 8'h04);
    wr(9'h170, 8'h00);
    wr(CTRL, 8'h35);
    wr(CTRL, 8'h00);
    rd(9'h160, v); check("R11 bulk erased block1", v, 8'h00);
    rd(9'h1BF, v); check("R11 bulk erased last", v, 8'h00);
    rd(9'h150, v); check("R11 bulk erased first block", v, 8'h00);

    // R1 reset mid operation
    wr(CTRL, 8'h0C);
    wr(CTRL, 8'h3D);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 pump cleared by reset", {7'd0, pump_en}, 8'h00);
    check("R1 rc_sel cleared by reset", {7'd0, rc_sel}, 8'h00);
    rd(CTRL, v); check("R1 ctrl cleared by reset", v, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(CTRL, v); check("R1 ctrl after second reset", v, 8'h00);

    finish_run();
  end
endmodule